// File: doc/BRIEF.md
# Video Memory Block Copy and Access Engine

This block sits behind an 8-bit processor I/O window of eight byte ports and owns a small video memory. It holds three pointers (a source pointer, a target pointer and a stride) plus a 16-bit transfer counter. The processor can store or fetch single bytes at the target pointer, with or without moving it. It can also load the counter to start a background copy, which moves bytes from the source run to the target run, and it can poll the counter to see how many bytes are still to go.

The memory is a synchronous single-port array with one access per clock. A processor access to memory always wins the port, and any copy step that wanted the port that cycle waits. Pointers are 16 bits wide and wrap modulo 2^16. The array holds 2^MEM_AW bytes and is indexed by the low MEM_AW pointer bits, so higher pointer bits alias. Every read request returns its byte on `io_rdata` with `io_rvalid` high exactly one clock after the request is sampled.

Top module: `vxe_engine`

## Requirements
- R1: Port offsets on `io_port`: 0 counter low, 1 counter high, 2 source low, 3 source high, 4 target low, 5 target high, 6 data with advance, 7 stride write / peek read. A read request returns its byte with `io_rvalid` high one clock later. After reset the counter, source and target are 0 and the stride is 1.
- R2: A write to port 1 only stores the counter's high byte. A write to port 0 stores the low byte and, if the resulting 16-bit counter is nonzero and no copy is running, starts a copy.
- R3: Reads of ports 0 and 1 return the low and high bytes of the number of copy steps still outstanding. The value falls to 0 when the copy ends.
- R4: A write to port 4 or port 5 sets the stride back to 1.
- R5: A write to port 6 stores the byte at the target pointer and then adds the stride, zero-extended to 16 bits, to the target pointer. The pointer wraps modulo 2^16.
- R6: A read of port 6 returns the byte at the target pointer and then adds the stride to the target pointer.
- R7: A read of port 7 returns the byte at the target pointer and leaves the pointer unchanged. A write to port 7 sets the stride.
- R8: Ports 2 to 5 read back the current source and target pointer bytes.
- R9: Each copy step reads the byte at the source pointer and writes it at the target pointer. It then adds the stride to both pointers and lowers the counter by one. After N steps the source and target have each moved by N times the stride.
- R10: Writing port 0 while the high counter byte is 0 and the written value is 0 starts no copy and changes no pointer or memory.
- R11: A processor data or peek access during a copy delays the copy by one cycle, and the bytes the copy stores are unchanged.
- R12: While a copy is outstanding, writes to ports 0 to 5 and 7 are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| io_req | input | 1 | Port access strobe, one access per cycle |
| io_we | input | 1 | 1 = write access, 0 = read access |
| io_port | input | 3 | Port offset within the window |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte, valid while io_rvalid is high |
| io_rvalid | output | 1 | Read response strobe, one clock after a read request |

## Verification
Copies are run with two stride values (1 and 3) and several lengths. This separates a design that advances by a fixed step from one that applies the programmed stride to both pointers. One copy is run while peek reads and register writes arrive mid-transfer. Its final pointers and memory contents show whether the port arbitration stalled the copy cleanly and whether writes during the copy were discarded. Single-byte writes that run the target pointer past 0xFFFF, peeks mixed with advancing reads, and writes to each target byte after a stride change show the pointer arithmetic and the stride reset. A zero-length start and a write of only the high counter byte check that nothing begins on its own.

// File: rtl/vxe_pkg.sv
package vxe_pkg;

  typedef enum logic [2:0] {
    P_CNT_LO = 3'd0,
    P_CNT_HI = 3'd1,
    P_SRC_LO = 3'd2,
    P_SRC_HI = 3'd3,
    P_TGT_LO = 3'd4,
    P_TGT_HI = 3'd5,
    P_DATA   = 3'd6,
    P_STEP   = 3'd7
  } port_e;

  typedef enum logic [1:0] {
    CP_IDLE  = 2'd0,
    CP_READ  = 2'd1,
    CP_WRITE = 2'd2
  } cp_state_e;

endpackage

// File: rtl/vxe_vram.sv
module vxe_vram #(
  parameter int DW     = 8,
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [MEM_AW-1:0] idx,
  input  logic [DW-1:0]     wd,
  output logic [DW-1:0]     q
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        mem[idx] <= wd;
      end else begin
        q <= mem[idx];
      end
    end
  end

endmodule

// File: rtl/vxe_copy_seq.sv
module vxe_copy_seq
  import vxe_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          grant,
  input  logic [CW-1:0] count,
  input  logic [DW-1:0] ram_q,
  output logic          busy,
  output logic          rd_req,
  output logic          wr_req,
  output logic [DW-1:0] wdata,
  output logic          step
);
  localparam logic [CW-1:0] LAST = CW'(1);

  cp_state_e     state_q, state_d;
  logic          fresh_q, fresh_d;
  logic [DW-1:0] hold_q, hold_d;

  assign busy  = (state_q != CP_IDLE);
  assign wdata = fresh_q ? ram_q : hold_q;

  always_comb begin
    state_d = state_q;
    fresh_d = fresh_q;
    hold_d  = hold_q;
    rd_req  = 1'b0;
    wr_req  = 1'b0;
    step    = 1'b0;
    unique case (state_q)
      CP_IDLE: begin
        if (start) state_d = CP_READ;
      end
      CP_READ: begin
        rd_req = 1'b1;
        if (grant) begin
          state_d = CP_WRITE;
          fresh_d = 1'b1;
        end
      end
      CP_WRITE: begin
        wr_req  = 1'b1;
        hold_d  = wdata;
        fresh_d = 1'b0;
        if (grant) begin
          step    = 1'b1;
          state_d = (count == LAST) ? CP_IDLE : CP_READ;
        end
      end
      default: state_d = CP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CP_IDLE;
      fresh_q <= 1'b0;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      fresh_q <= fresh_d;
      if (busy) hold_q <= hold_d;
    end
  end

  // R9
  busy_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (count != '0));

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

endmodule

// File: rtl/vxe_regfile.sv
module vxe_regfile
  import vxe_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  port_e         port,
  input  logic [DW-1:0] wdata,
  input  logic          busy,
  input  logic          cpu_adv,
  input  logic          step,
  output logic [AW-1:0] src,
  output logic [AW-1:0] tgt,
  output logic [CW-1:0] cnt,
  output logic [DW-1:0] stride,
  output logic          start
);
  localparam logic [DW-1:0] STRIDE_RST = DW'(1);

  logic [AW-1:0] src_d, tgt_d;
  logic [CW-1:0] cnt_d;
  logic [DW-1:0] stride_d;
  logic [AW-1:0] delta;
  logic [CW-1:0] cnt_load;
  logic          wr_ok;

  assign delta    = {{(AW-DW){1'b0}}, stride};
  assign wr_ok    = wr_en && !busy;
  assign cnt_load = {cnt[CW-1:DW], wdata};
  assign start    = wr_ok && (port == P_CNT_LO) && (cnt_load != '0);

  always_comb begin
    src_d    = src;
    tgt_d    = tgt;
    cnt_d    = cnt;
    stride_d = stride;
    if (wr_ok) begin
      unique case (port)
        P_CNT_LO: cnt_d = cnt_load;
        P_CNT_HI: cnt_d[CW-1:DW] = wdata;
        P_SRC_LO: src_d[DW-1:0] = wdata;
        P_SRC_HI: src_d[AW-1:DW] = wdata;
        P_TGT_LO: begin
          tgt_d[DW-1:0] = wdata;
          stride_d      = STRIDE_RST;
        end
        P_TGT_HI: begin
          tgt_d[AW-1:DW] = wdata;
          stride_d       = STRIDE_RST;
        end
        P_STEP:   stride_d = wdata;
        default:  ;
      endcase
    end
    if (cpu_adv) begin
      tgt_d = tgt + delta;
    end
    if (step) begin
      src_d = src + delta;
      tgt_d = tgt + delta;
      cnt_d = cnt - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src    <= '0;
      tgt    <= '0;
      cnt    <= '0;
      stride <= STRIDE_RST;
    end else begin
      src    <= src_d;
      tgt    <= tgt_d;
      cnt    <= cnt_d;
      stride <= stride_d;
    end
  end

  // R12
  frozen_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step) |=> $stable(src));

  // R12
  frozen_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(stride));

endmodule

// File: rtl/vxe_engine.sv
module vxe_engine
  import vxe_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int CW     = 16,
  parameter int MEM_AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_req,
  input  logic          io_we,
  input  logic [2:0]    io_port,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] io_rdata,
  output logic          io_rvalid
);
  port_e         port;
  logic [AW-1:0] src, tgt;
  logic [CW-1:0] cnt;
  logic [DW-1:0] stride;
  logic          start, busy, step;
  logic          cp_rd_req, cp_wr_req;
  logic [DW-1:0] cp_wdata;
  logic          cpu_ram, cpu_adv, grant;
  logic          ram_en, ram_we;
  logic [MEM_AW-1:0] ram_idx;
  logic [DW-1:0] ram_wd, ram_q;
  logic          rd_hit;
  logic [DW-1:0] snap;
  logic          rvalid_q, from_ram_q;
  logic [DW-1:0] byte_q;

  assign port    = port_e'(io_port);
  assign cpu_adv = io_req && (port == P_DATA);
  assign cpu_ram = cpu_adv || (io_req && !io_we && (port == P_STEP));
  assign grant   = !cpu_ram;
  assign rd_hit  = io_req && !io_we;

  // memory port arbitration: processor first, copy waits
  assign ram_en  = cpu_ram || (grant && (cp_rd_req || cp_wr_req));
  assign ram_we  = cpu_ram ? io_we : cp_wr_req;
  assign ram_idx = (cpu_ram || !cp_rd_req) ? tgt[MEM_AW-1:0] : src[MEM_AW-1:0];
  assign ram_wd  = cpu_ram ? io_wdata : cp_wdata;

  vxe_regfile #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (io_req && io_we),
    .port    (port),
    .wdata   (io_wdata),
    .busy    (busy),
    .cpu_adv (cpu_adv),
    .step    (step),
    .src     (src),
    .tgt     (tgt),
    .cnt     (cnt),
    .stride  (stride),
    .start   (start)
  );

  vxe_copy_seq #(.DW(DW), .CW(CW)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .grant  (grant),
    .count  (cnt),
    .ram_q  (ram_q),
    .busy   (busy),
    .rd_req (cp_rd_req),
    .wr_req (cp_wr_req),
    .wdata  (cp_wdata),
    .step   (step)
  );

  vxe_vram #(.DW(DW), .MEM_AW(MEM_AW)) u_ram (
    .clk (clk),
    .en  (ram_en),
    .we  (ram_we),
    .idx (ram_idx),
    .wd  (ram_wd),
    .q   (ram_q)
  );

  always_comb begin
    unique case (port)
      P_CNT_LO: snap = cnt[DW-1:0];
      P_CNT_HI: snap = cnt[CW-1:DW];
      P_SRC_LO: snap = src[DW-1:0];
      P_SRC_HI: snap = src[AW-1:DW];
      P_TGT_LO: snap = tgt[DW-1:0];
      P_TGT_HI: snap = tgt[AW-1:DW];
      default:  snap = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q   <= 1'b0;
      from_ram_q <= 1'b0;
      byte_q     <= '0;
    end else begin
      rvalid_q   <= rd_hit;
      from_ram_q <= cpu_ram && !io_we;
      if (rd_hit) byte_q <= snap;
    end
  end

  assign io_rvalid = rvalid_q;
  assign io_rdata  = from_ram_q ? ram_q : byte_q;

  // R1
  rsp_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> io_rvalid);

  // R4
  tgt_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && io_we && !busy && (port == P_TGT_LO || port == P_TGT_HI))
      |=> (stride == DW'(1)));

  // R7
  peek_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && !io_we && (port == P_STEP)) |=> $stable(tgt));

  // R11
  cpu_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ram && busy) |=> $stable(cnt));

  // R10
  zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && io_we && !busy && (port == P_CNT_LO) &&
     (cnt[CW-1:DW] == '0) && (io_wdata == '0)) |=> !busy);

endmodule

// File: tb/vxe_engine_tb.sv
module vxe_engine_tb;
  localparam int P_CLO = 0, P_CHI = 1, P_SLO = 2, P_SHI = 3;
  localparam int P_TLO = 4, P_THI = 5, P_DAT = 6, P_STP = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       io_req = 1'b0;
  logic       io_we = 1'b0;
  logic [2:0] io_port = '0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic       io_rvalid;

  int total = 0;
  int bad = 0;

  logic [7:0] exp_q[$];
  bit         dc_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  vxe_engine u_dut (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_we(io_we),
    .io_port(io_port), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .io_rvalid(io_rvalid)
  );

  // monitor: pops the scoreboard as responses appear
  always @(negedge clk) begin
    if (rst_n && io_rvalid) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R1 unexpected response got=%h exp=none", io_rdata);
      end else begin
        logic [7:0] e;
        bit d;
        string t;
        e = exp_q.pop_front();
        d = dc_q.pop_front();
        t = tag_q.pop_front();
        if (!d) begin
          total++;
          if (io_rdata !== e) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", t, io_rdata, e);
          end
        end
      end
    end
  end

  task automatic wr(input int p, input logic [7:0] v);
    @(negedge clk);
    io_req = 1'b1; io_we = 1'b1; io_port = 3'(p); io_wdata = v;
    @(negedge clk);
    io_req = 1'b0; io_we = 1'b0;
  endtask

  task automatic rd_exp(input int p, input logic [7:0] e, input string t);
    @(negedge clk);
    io_req = 1'b1; io_we = 1'b0; io_port = 3'(p);
    exp_q.push_back(e); dc_q.push_back(1'b0); tag_q.push_back(t);
    @(negedge clk);
    io_req = 1'b0;
  endtask

  task automatic rd_get(input int p, output logic [7:0] v);
    @(negedge clk);
    io_req = 1'b1; io_we = 1'b0; io_port = 3'(p);
    exp_q.push_back(8'h00); dc_q.push_back(1'b1); tag_q.push_back("dc");
    @(negedge clk);
    io_req = 1'b0;
    v = io_rdata;
  endtask

  task automatic chk(input bit ok, input string t, input int got, input int e);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", t, got, e);
    end
  endtask

  task automatic set_tgt(input logic [15:0] a);
    wr(P_THI, a[15:8]);
    wr(P_TLO, a[7:0]);
  endtask

  task automatic set_src(input logic [15:0] a);
    wr(P_SHI, a[15:8]);
    wr(P_SLO, a[7:0]);
  endtask

  task automatic wait_done(output int first);
    logic [7:0] lo, hi;
    first = -1;
    for (int k = 0; k < 2000; k++) begin
      rd_get(P_CLO, lo);
      rd_get(P_CHI, hi);
      if (first < 0) first = int'({hi, lo});
      if (lo == 8'h00 && hi == 8'h00) break;
    end
  endtask

  initial begin
    #(20 * 190000);
    total++; bad++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int first;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd_exp(P_CLO, 8'h00, "R1 reset cnt lo");
    rd_exp(P_CHI, 8'h00, "R1 reset cnt hi");
    rd_exp(P_SLO, 8'h00, "R1 reset src lo");
    rd_exp(P_SHI, 8'h00, "R1 reset src hi");
    rd_exp(P_TLO, 8'h00, "R1 reset tgt lo");
    rd_exp(P_THI, 8'h00, "R1 reset tgt hi");
    wr(P_DAT, 8'h11);
    rd_exp(P_TLO, 8'h01, "R1 reset stride one");

    // R5 writes with stride 3
    set_tgt(16'h0100);
    wr(P_STP, 8'd3);
    wr(P_DAT, 8'hA0); wr(P_DAT, 8'hA1); wr(P_DAT, 8'hA2);
    rd_exp(P_TLO, 8'h09, "R5 target after three writes");

    // R6 / R7 reads, peeks
    set_tgt(16'h0100);
    wr(P_STP, 8'd3);
    rd_exp(P_DAT, 8'hA0, "R6 data read");
    rd_exp(P_STP, 8'hA1, "R7 peek");
    rd_exp(P_STP, 8'hA1, "R7 peek repeat");
    rd_exp(P_TLO, 8'h03, "R7 peek keeps target");
    rd_exp(P_DAT, 8'hA1, "R6 second data read");
    rd_exp(P_TLO, 8'h06, "R6 target advanced");

    // R4 target high write resets stride
    wr(P_THI, 8'h01);
    wr(P_DAT, 8'h77);
    rd_exp(P_TLO, 8'h07, "R4 stride one after tgt hi write");
    wr(P_STP, 8'd5);
    wr(P_TLO, 8'h06);
    rd_exp(P_DAT, 8'h77, "R5 stored byte");
    rd_exp(P_TLO, 8'h07, "R4 stride one after tgt lo write");

    // R5 wrap
    set_tgt(16'hFFFF);
    wr(P_STP, 8'd2);
    wr(P_DAT, 8'h5C);
    rd_exp(P_THI, 8'h00, "R5 wrap hi");
    rd_exp(P_TLO, 8'h01, "R5 wrap lo");

    // R8 source readback
    set_src(16'h1234);
    rd_exp(P_SLO, 8'h34, "R8 src lo");
    rd_exp(P_SHI, 8'h12, "R8 src hi");

    // copy, stride 1, five bytes
    set_tgt(16'h0200);
    for (int i = 0; i < 5; i++) wr(P_DAT, 8'(8'hC0 + i));
    set_src(16'h0200);
    set_tgt(16'h0280);
    wr(P_CHI, 8'h01);
    repeat (4) @(negedge clk);
    rd_exp(P_CHI, 8'h01, "R2 hi stored");
    rd_exp(P_CLO, 8'h00, "R2 hi write did not start");
    rd_exp(P_TLO, 8'h80, "R2 hi write left target");
    wr(P_CHI, 8'h00);
    wr(P_CLO, 8'h05);
    wait_done(first);
    chk(first > 0 && first <= 5, "R3 outstanding count in range", first, 5);
    rd_exp(P_CLO, 8'h00, "R3 count done");
    rd_exp(P_SLO, 8'h05, "R9 src end");
    rd_exp(P_TLO, 8'h85, "R9 tgt end");
    set_tgt(16'h0280);
    for (int i = 0; i < 5; i++) rd_exp(P_DAT, 8'(8'hC0 + i), "R9 copied byte");

    // copy, stride 3, twelve bytes, with peeks and writes mid-copy
    for (int i = 0; i < 12; i++) begin
      set_tgt(16'(16'h0300 + 3 * i));
      wr(P_DAT, 8'(8'h40 + i));
    end
    set_src(16'h0300);
    set_tgt(16'h0340);
    wr(P_STP, 8'd3);
    wr(P_CLO, 8'd12);
    rd_get(P_STP, first[7:0]);
    rd_get(P_STP, first[7:0]);
    rd_get(P_STP, first[7:0]);
    wr(P_SLO, 8'hEE);
    wr(P_STP, 8'd1);
    wr(P_CHI, 8'h07);
    wait_done(first);
    rd_exp(P_CHI, 8'h00, "R12 count hi write dropped");
    rd_exp(P_SLO, 8'h24, "R12 src write dropped");
    rd_exp(P_SHI, 8'h03, "R9 src hi end");
    rd_exp(P_TLO, 8'h64, "R12 stride write dropped");
    set_tgt(16'h0340);
    wr(P_STP, 8'd3);
    for (int i = 0; i < 12; i++) rd_exp(P_DAT, 8'(8'h40 + i), "R11 byte after stalled copy");

    // R10 zero count
    set_tgt(16'h0600);
    wr(P_DAT, 8'h99);
    set_tgt(16'h0600);
    set_src(16'h0500);
    wr(P_CHI, 8'h00);
    wr(P_CLO, 8'h00);
    repeat (4) @(negedge clk);
    rd_exp(P_CLO, 8'h00, "R10 count stays zero");
    rd_exp(P_SHI, 8'h05, "R10 src unchanged");
    rd_exp(P_TLO, 8'h00, "R10 tgt unchanged");
    rd_exp(P_STP, 8'h99, "R10 memory unchanged");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all responses seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule